// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block turns one transfer request into the ordered list of beat addresses that the memory-mapped side of a DMA channel must issue. A request gives a base address and a row-to-row stride for each side, a row length X and a row count Y (both programmed as the count minus one), an identifier and a cyclic flag. The generator walks X bytes of each row in steps of the bus width, then moves each side's row start forward by that side's own stride, for Y rows. Each beat carries one source address and one destination address, a flag on the final beat of every row and a flag on the final beat of the request.

Requests are taken through a valid/ready handshake while the generator is idle. Beats leave through a valid/ready handshake that may stall at any time. When the final beat of a non-cyclic request is accepted, a one-cycle completion pulse carries the request identifier. A cyclic request starts again from its first row after its last row and never completes. A side that is configured as a stream has no address, and its beat address is always zero.

Software discovers the build options through a combinational probe port. Writing a trial value for a length or address field returns the value that the field would actually hold. A descriptor word reports each side's bus width and whether that side is memory-mapped. Request fields are cut down by exactly the same rules when a request is accepted.

Top module: `dma2d_addrgen`

## Requirements
- R1: After reset, req_ready is 1 and beat_valid and done_valid are 0.
- R2: A request is taken in the cycle where req_valid and req_ready are both 1. beat_valid is 1 from the following cycle onward, and req_ready stays 0 while beats remain to be issued.
- R3: Within a row, beat k carries the row start address plus k times the beat size. The beat size is the wider of the two bus widths in bytes (8 by default). A row holds (X+1)/8 beats, and beat_row_last is 1 on its final beat only.
- R4: The start of row r is the base plus r times the stride, computed separately for source and destination with their own strides.
- R5: A request issues Y+1 rows. beat_req_last is 1 only on the final beat of the final row, and that beat also has beat_row_last set.
- R6: One cycle after the final beat of a non-cyclic request is accepted, done_valid is 1 for exactly one cycle and done_id equals the request ID. After that beat, beat_valid is 0 and req_ready is 1.
- R7: While beat_valid is 1 and beat_ready is 0, the beat addresses and both flags hold their values.
- R8: With req_cyclic set, the beat after the final beat of the final row is row 0, beat 0 again, and done_valid never rises.
- R9: The X length probe (probe_sel 0) returns the trial value cut to the 12-bit length field with the low alignment bits forced to 1. All ones reads back 0xFFF and zero reads back 0x7. A request's X length is normalised the same way.
- R10: The Y length probe (probe_sel 1) returns the trial value cut to 8 bits when two-dimensional support is built in, so writing 1 reads back 1. Without that support it returns 0, and every request issues a single row.
- R11: The address probes (probe_sel 2 for source, 3 for destination) return the trial value with the alignment bits cleared on a memory-mapped side, and 0 on a streaming side. Request addresses and strides are aligned the same way, and a streaming side's beat address is always 0.
- R12: The descriptor probe (probe_sel 4) returns the destination width as log2 of bytes in bits 3:0 and the source width in bits 7:4. Bit 8 is 1 when the source is memory-mapped and bit 9 when the destination is. All other probe_sel values read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_src_addr | input | 32 | Source base address |
| req_dst_addr | input | 32 | Destination base address |
| req_src_stride | input | 32 | Source row-to-row stride in bytes |
| req_dst_stride | input | 32 | Destination row-to-row stride in bytes |
| req_xlen_m1 | input | 12 | Row length in bytes minus one |
| req_ylen_m1 | input | 8 | Row count minus one |
| req_cyclic | input | 1 | Repeat the request without end |
| req_id | input | 5 | Request identifier |
| beat_valid | output | 1 | Beat address available |
| beat_ready | input | 1 | Beat accepted by downstream |
| beat_src_addr | output | 32 | Source address of this beat |
| beat_dst_addr | output | 32 | Destination address of this beat |
| beat_row_last | output | 1 | Final beat of a row |
| beat_req_last | output | 1 | Final beat of the request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | 5 | Identifier of the completed request |
| probe_sel | input | 3 | Capability probe field select |
| probe_wdata | input | 32 | Trial value for the probed field |
| probe_rdata | output | 32 | Value the probed field would hold |

## Verification
On every cycle the assertions check the handshake rules: a beat follows an accepted request, no request is taken while beats are pending, the outputs hold under backpressure, and addresses step by the beat size inside a row. They also check that beats stay aligned, that a streaming side stays at zero, and that a completion pulse is single and follows a last beat. Row-to-row stride arithmetic, row and beat counts, wrap-around in cyclic mode, identifier delivery and the probe readback values depend on the request contents. Only the bench scenarios show these, by comparing every beat against addresses computed from the requirements for several geometries, unaligned inputs, stalls and a build with a flat, streaming-destination channel.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    // Field widths shared by the generator, its probe and its checker
    localparam int AG_ADDR_W = 32;
    localparam int AG_XLEN_W = 12;
    localparam int AG_YLEN_W = 8;
    localparam int AG_ID_W   = 5;
    localparam int AG_REG_W  = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ag_state_e;

    typedef enum logic [2:0] {
        PRB_XLEN     = 3'd0,
        PRB_YLEN     = 3'd1,
        PRB_SRC_ADDR = 3'd2,
        PRB_DST_ADDR = 3'd3,
        PRB_DESC     = 3'd4
    } ag_probe_e;

    typedef struct packed {
        logic [AG_ADDR_W-1:0] src_base;
        logic [AG_ADDR_W-1:0] dst_base;
        logic [AG_ADDR_W-1:0] src_stride;
        logic [AG_ADDR_W-1:0] dst_stride;
        logic [AG_XLEN_W-1:0] xlen_m1;
        logic [AG_YLEN_W-1:0] ylen_m1;
        logic                 cyclic;
        logic [AG_ID_W-1:0]   id;
    } ag_req_t;

    function automatic int unsigned wider_log2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dma2d_norm.sv
module dma2d_norm
    import dma2d_pkg::*;
#(
    parameter int unsigned SRC_LOG2 = 2,
    parameter int unsigned DST_LOG2 = 3,
    parameter bit          SRC_MEM  = 1'b1,
    parameter bit          DST_MEM  = 1'b1,
    parameter bit          HAS_2D   = 1'b1
) (
    input  ag_req_t              raw,
    output ag_req_t              norm,
    input  logic [2:0]           probe_sel,
    input  logic [AG_REG_W-1:0]  probe_wdata,
    output logic [AG_REG_W-1:0]  probe_rdata
);
    localparam int unsigned WIDE_LOG2 = wider_log2(SRC_LOG2, DST_LOG2);
    localparam logic [AG_ADDR_W-1:0] ALIGN_M = AG_ADDR_W'((1 << WIDE_LOG2) - 1);
    localparam logic [AG_XLEN_W-1:0] XALIGN  = ALIGN_M[AG_XLEN_W-1:0];

    // Field rules, used both for request capture and for the probe
    function automatic logic [AG_ADDR_W-1:0] fix_addr(logic [AG_ADDR_W-1:0] v, bit is_mem);
        return is_mem ? (v & ~ALIGN_M) : '0;
    endfunction

    function automatic logic [AG_XLEN_W-1:0] fix_xlen(logic [AG_XLEN_W-1:0] v);
        return v | XALIGN;
    endfunction

    function automatic logic [AG_YLEN_W-1:0] fix_ylen(logic [AG_YLEN_W-1:0] v);
        return HAS_2D ? v : '0;
    endfunction

    always_comb begin
        norm            = raw;
        norm.src_base   = fix_addr(raw.src_base,   SRC_MEM);
        norm.dst_base   = fix_addr(raw.dst_base,   DST_MEM);
        norm.src_stride = fix_addr(raw.src_stride, SRC_MEM);
        norm.dst_stride = fix_addr(raw.dst_stride, DST_MEM);
        norm.xlen_m1    = fix_xlen(raw.xlen_m1);
        norm.ylen_m1    = fix_ylen(raw.ylen_m1);
    end

    always_comb begin
        unique case (probe_sel)
            PRB_XLEN:     probe_rdata = AG_REG_W'(fix_xlen(probe_wdata[AG_XLEN_W-1:0]));
            PRB_YLEN:     probe_rdata = AG_REG_W'(fix_ylen(probe_wdata[AG_YLEN_W-1:0]));
            PRB_SRC_ADDR: probe_rdata = AG_REG_W'(fix_addr(probe_wdata, SRC_MEM));
            PRB_DST_ADDR: probe_rdata = AG_REG_W'(fix_addr(probe_wdata, DST_MEM));
            PRB_DESC:     probe_rdata = AG_REG_W'({DST_MEM, SRC_MEM,
                                                   4'(SRC_LOG2), 4'(DST_LOG2)});
            default:      probe_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma2d_col_cnt.sv
module dma2d_col_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last_idx,
    output logic [W-1:0] idx,
    output logic         at_last
);
    assign at_last = (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= at_last ? '0 : idx + W'(1);
        end
    end

endmodule

// File: rtl/dma2d_row_walk.sv
module dma2d_row_walk #(
    parameter int AW = 32,
    parameter int YW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_src,
    input  logic [AW-1:0] load_dst,
    input  logic [AW-1:0] wrap_src,
    input  logic [AW-1:0] wrap_dst,
    input  logic [AW-1:0] src_stride,
    input  logic [AW-1:0] dst_stride,
    input  logic [YW-1:0] last_row,
    input  logic          step,
    output logic [AW-1:0] row_src,
    output logic [AW-1:0] row_dst,
    output logic          at_last_row
);
    logic [YW-1:0] row_idx;

    assign at_last_row = (row_idx == last_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_idx <= '0;
            row_src <= '0;
            row_dst <= '0;
        end else if (load) begin
            row_idx <= '0;
            row_src <= load_src;
            row_dst <= load_dst;
        end else if (step) begin
            if (at_last_row) begin
                row_idx <= '0;
                row_src <= wrap_src;
                row_dst <= wrap_dst;
            end else begin
                row_idx <= row_idx + YW'(1);
                row_src <= row_src + src_stride;
                row_dst <= row_dst + dst_stride;
            end
        end
    end

endmodule

// File: rtl/dma2d_addrgen.sv
module dma2d_addrgen
    import dma2d_pkg::*;
#(
    parameter int unsigned SRC_LOG2 = 2,
    parameter int unsigned DST_LOG2 = 3,
    parameter bit          SRC_MEM  = 1'b1,
    parameter bit          DST_MEM  = 1'b1,
    parameter bit          HAS_2D   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AG_ADDR_W-1:0] req_src_addr,
    input  logic [AG_ADDR_W-1:0] req_dst_addr,
    input  logic [AG_ADDR_W-1:0] req_src_stride,
    input  logic [AG_ADDR_W-1:0] req_dst_stride,
    input  logic [AG_XLEN_W-1:0] req_xlen_m1,
    input  logic [AG_YLEN_W-1:0] req_ylen_m1,
    input  logic                 req_cyclic,
    input  logic [AG_ID_W-1:0]   req_id,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [AG_ADDR_W-1:0] beat_src_addr,
    output logic [AG_ADDR_W-1:0] beat_dst_addr,
    output logic                 beat_row_last,
    output logic                 beat_req_last,
    output logic                 done_valid,
    output logic [AG_ID_W-1:0]   done_id,
    input  logic [2:0]           probe_sel,
    input  logic [AG_REG_W-1:0]  probe_wdata,
    output logic [AG_REG_W-1:0]  probe_rdata
);
    localparam int unsigned WIDE_LOG2 = wider_log2(SRC_LOG2, DST_LOG2);
    localparam int          COL_W     = AG_XLEN_W - int'(WIDE_LOG2);

    ag_state_e           state;
    ag_req_t             raw_req;
    ag_req_t             norm_req;
    ag_req_t             cur;
    logic                accept;
    logic                fire;
    logic                row_end;
    logic                req_end;
    logic [COL_W-1:0]    col_idx;
    logic [COL_W-1:0]    col_last;
    logic                col_at_last;
    logic                row_at_last;
    logic [AG_ADDR_W-1:0] row_src;
    logic [AG_ADDR_W-1:0] row_dst;
    logic [AG_ADDR_W-1:0] col_offset;

    always_comb begin
        raw_req.src_base   = req_src_addr;
        raw_req.dst_base   = req_dst_addr;
        raw_req.src_stride = req_src_stride;
        raw_req.dst_stride = req_dst_stride;
        raw_req.xlen_m1    = req_xlen_m1;
        raw_req.ylen_m1    = req_ylen_m1;
        raw_req.cyclic     = req_cyclic;
        raw_req.id         = req_id;
    end

    dma2d_norm #(
        .SRC_LOG2 (SRC_LOG2),
        .DST_LOG2 (DST_LOG2),
        .SRC_MEM  (SRC_MEM),
        .DST_MEM  (DST_MEM),
        .HAS_2D   (HAS_2D)
    ) u_norm (
        .raw         (raw_req),
        .norm        (norm_req),
        .probe_sel   (probe_sel),
        .probe_wdata (probe_wdata),
        .probe_rdata (probe_rdata)
    );

    assign req_ready  = (state == ST_IDLE);
    assign beat_valid = (state == ST_RUN);
    assign accept     = req_valid && req_ready;
    assign fire       = beat_valid && beat_ready;
    assign row_end    = fire && col_at_last;
    assign req_end    = row_end && row_at_last;
    assign col_last   = COL_W'(cur.xlen_m1 >> WIDE_LOG2);

    dma2d_col_cnt #(
        .W (COL_W)
    ) u_col (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (fire),
        .last_idx (col_last),
        .idx      (col_idx),
        .at_last  (col_at_last)
    );

    dma2d_row_walk #(
        .AW (AG_ADDR_W),
        .YW (AG_YLEN_W)
    ) u_row (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .load_src    (norm_req.src_base),
        .load_dst    (norm_req.dst_base),
        .wrap_src    (cur.src_base),
        .wrap_dst    (cur.dst_base),
        .src_stride  (cur.src_stride),
        .dst_stride  (cur.dst_stride),
        .last_row    (cur.ylen_m1),
        .step        (row_end),
        .row_src     (row_src),
        .row_dst     (row_dst),
        .at_last_row (row_at_last)
    );

    assign col_offset = AG_ADDR_W'(col_idx) << WIDE_LOG2;

    generate
        if (SRC_MEM) begin : g_src_mem
            assign beat_src_addr = row_src + col_offset;
        end else begin : g_src_stream
            assign beat_src_addr = '0;
        end
        if (DST_MEM) begin : g_dst_mem
            assign beat_dst_addr = row_dst + col_offset;
        end else begin : g_dst_stream
            assign beat_dst_addr = '0;
        end
    endgenerate

    assign beat_row_last = col_at_last;
    assign beat_req_last = col_at_last && row_at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            done_valid <= 1'b0;
            done_id    <= '0;
        end else begin
            done_valid <= req_end && !cur.cyclic;
            if (req_end && !cur.cyclic) begin
                done_id <= cur.id;
            end
            if (accept) begin
                cur   <= norm_req;
                state <= ST_RUN;
            end else if (req_end && !cur.cyclic) begin
                state <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/dma2d_addrgen_chk.sv
module dma2d_addrgen_chk
    import dma2d_pkg::*;
#(
    parameter int unsigned SRC_LOG2 = 2,
    parameter int unsigned DST_LOG2 = 3,
    parameter bit          SRC_MEM  = 1'b1,
    parameter bit          DST_MEM  = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 beat_valid,
    input logic                 beat_ready,
    input logic [AG_ADDR_W-1:0] beat_src_addr,
    input logic [AG_ADDR_W-1:0] beat_dst_addr,
    input logic                 beat_row_last,
    input logic                 beat_req_last,
    input logic                 done_valid
);
    localparam int unsigned WIDE_LOG2 = wider_log2(SRC_LOG2, DST_LOG2);
    localparam logic [AG_ADDR_W-1:0] STEP    = AG_ADDR_W'(1 << WIDE_LOG2);
    localparam logic [AG_ADDR_W-1:0] ALIGN_M = STEP - AG_ADDR_W'(1);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> beat_valid);

    // R2
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_src_addr)
            && $stable(beat_dst_addr) && $stable(beat_row_last) && $stable(beat_req_last));

    // R3
    src_step_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_row_last |=>
            (SRC_MEM == 1'b0) || (beat_src_addr == $past(beat_src_addr) + STEP));

    // R3
    dst_step_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_row_last |=>
            (DST_MEM == 1'b0) || (beat_dst_addr == $past(beat_dst_addr) + STEP));

    // R5
    req_last_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_req_last |-> beat_row_last);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(beat_valid && beat_ready && beat_req_last));

    // R11
    beat_align_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> ((beat_src_addr & ALIGN_M) == '0) && ((beat_dst_addr & ALIGN_M) == '0));

    // R11
    stream_zero_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (SRC_MEM || beat_src_addr == '0) && (DST_MEM || beat_dst_addr == '0));

endmodule

bind dma2d_addrgen dma2d_addrgen_chk #(
    .SRC_LOG2 (SRC_LOG2),
    .DST_LOG2 (DST_LOG2),
    .SRC_MEM  (SRC_MEM),
    .DST_MEM  (DST_MEM)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .beat_valid    (beat_valid),
    .beat_ready    (beat_ready),
    .beat_src_addr (beat_src_addr),
    .beat_dst_addr (beat_dst_addr),
    .beat_row_last (beat_row_last),
    .beat_req_last (beat_req_last),
    .done_valid    (done_valid)
);

// File: tb/dma2d_addrgen_tb.sv
module dma2d_addrgen_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] ss;
        logic [31:0] ds;
        logic [11:0] x;
        logic [7:0]  y;
        logic [4:0]  id;
        logic        stall;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'h0000_8000, 32'h0000_0100, 32'h0000_0040, 12'd15, 8'd2, 5'd3,  1'b0},
        '{32'h0000_3000, 32'h0000_A000, 32'h0000_0080, 32'h0000_0080, 12'd7,  8'd0, 5'd31, 1'b1},
        '{32'h0001_0000, 32'h0002_0000, 32'h0000_0020, 32'h0000_1000, 12'd31, 8'd3, 5'd9,  1'b1},
        '{32'h0000_2005, 32'h0000_9000, 32'h0000_0033, 32'h0000_0080, 12'd12, 8'd1, 5'd17, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Main instance: both sides memory-mapped, 2D present
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_src_addr = '0, req_dst_addr = '0, req_src_stride = '0, req_dst_stride = '0;
    logic [11:0] req_xlen_m1 = '0;
    logic [7:0]  req_ylen_m1 = '0;
    logic        req_cyclic = 1'b0;
    logic [4:0]  req_id = '0;
    logic        beat_valid, beat_row_last, beat_req_last, done_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_src_addr, beat_dst_addr;
    logic [4:0]  done_id;
    logic [2:0]  probe_sel = '0;
    logic [31:0] probe_wdata = '0;
    logic [31:0] probe_rdata;

    dma2d_addrgen u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
        .req_src_stride(req_src_stride), .req_dst_stride(req_dst_stride),
        .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
        .req_cyclic(req_cyclic), .req_id(req_id),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_src_addr(beat_src_addr), .beat_dst_addr(beat_dst_addr),
        .beat_row_last(beat_row_last), .beat_req_last(beat_req_last),
        .done_valid(done_valid), .done_id(done_id),
        .probe_sel(probe_sel), .probe_wdata(probe_wdata), .probe_rdata(probe_rdata)
    );

    // Second instance: no 2D, streaming destination
    logic        f_req_valid = 1'b0;
    logic        f_req_ready;
    logic        f_beat_valid, f_beat_row_last, f_beat_req_last, f_done_valid;
    logic        f_beat_ready = 1'b0;
    logic [31:0] f_beat_src_addr, f_beat_dst_addr;
    logic [4:0]  f_done_id;
    logic [2:0]  f_probe_sel = '0;
    logic [31:0] f_probe_rdata;

    dma2d_addrgen #(.SRC_MEM(1'b1), .DST_MEM(1'b0), .HAS_2D(1'b0)) u_flat (
        .clk(clk), .rst(rst),
        .req_valid(f_req_valid), .req_ready(f_req_ready),
        .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
        .req_src_stride(req_src_stride), .req_dst_stride(req_dst_stride),
        .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
        .req_cyclic(req_cyclic), .req_id(req_id),
        .beat_valid(f_beat_valid), .beat_ready(f_beat_ready),
        .beat_src_addr(f_beat_src_addr), .beat_dst_addr(f_beat_dst_addr),
        .beat_row_last(f_beat_row_last), .beat_req_last(f_beat_req_last),
        .done_valid(f_done_valid), .done_id(f_done_id),
        .probe_sel(f_probe_sel), .probe_wdata(probe_wdata), .probe_rdata(f_probe_rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_req(input vec_t v, input bit cyc);
        req_src_addr   = v.src;
        req_dst_addr   = v.dst;
        req_src_stride = v.ss;
        req_dst_stride = v.ds;
        req_xlen_m1    = v.x;
        req_ylen_m1    = v.y;
        req_id         = v.id;
        req_cyclic     = cyc;
    endtask

    task automatic run_vec(input vec_t v, input int n);
        logic [31:0] sb, db, ss, ds, es, ed, hold_s;
        int nb, rows;
        sb   = v.src & ~32'h7;
        db   = v.dst & ~32'h7;
        ss   = v.ss & ~32'h7;
        ds   = v.ds & ~32'h7;
        nb   = (int'(v.x | 12'h7) + 1) / 8;
        rows = int'(v.y) + 1;
        drive_req(v, 1'b0);
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2", $sformatf("vec%0d ready before", n), {31'b0, req_ready}, 1);
        tick();
        req_valid = 1'b0;
        chk(beat_valid == 1'b1, "R2", $sformatf("vec%0d valid after accept", n), {31'b0, beat_valid}, 1);
        chk(req_ready == 1'b0, "R2", $sformatf("vec%0d busy", n), {31'b0, req_ready}, 0);
        for (int r = 0; r < rows; r++) begin
            for (int b = 0; b < nb; b++) begin
                es = sb + 32'(r) * ss + 32'(b * 8);
                ed = db + 32'(r) * ds + 32'(b * 8);
                if (v.stall && b == 0) begin
                    beat_ready = 1'b0;
                    hold_s = beat_src_addr;
                    tick();
                    tick();
                    // R7
                    chk(beat_valid && beat_src_addr == hold_s, "R7",
                        $sformatf("vec%0d stall hold", n), beat_src_addr, hold_s);
                end
                beat_ready = 1'b1;
                chk(beat_valid == 1'b1, "R5", $sformatf("vec%0d r%0d b%0d valid", n, r, b),
                    {31'b0, beat_valid}, 1);
                // R3 R4
                chk(beat_src_addr == es, "R4", $sformatf("vec%0d r%0d b%0d src", n, r, b),
                    beat_src_addr, es);
                chk(beat_dst_addr == ed, "R3", $sformatf("vec%0d r%0d b%0d dst", n, r, b),
                    beat_dst_addr, ed);
                chk(beat_row_last == (b == nb - 1), "R3", $sformatf("vec%0d r%0d b%0d row_last", n, r, b),
                    {31'b0, beat_row_last}, {31'b0, b == nb - 1});
                chk(beat_req_last == (b == nb - 1 && r == rows - 1), "R5",
                    $sformatf("vec%0d r%0d b%0d req_last", n, r, b),
                    {31'b0, beat_req_last}, {31'b0, b == nb - 1 && r == rows - 1});
                tick();
            end
        end
        beat_ready = 1'b0;
        chk(done_valid == 1'b1, "R6", $sformatf("vec%0d done", n), {31'b0, done_valid}, 1);
        chk(done_id == v.id, "R6", $sformatf("vec%0d done_id", n), {27'b0, done_id}, {27'b0, v.id});
        chk(beat_valid == 1'b0 && req_ready == 1'b1, "R6", $sformatf("vec%0d idle", n),
            {30'b0, beat_valid, req_ready}, 32'h1);
        tick();
        chk(done_valid == 1'b0, "R6", $sformatf("vec%0d done one cycle", n), {31'b0, done_valid}, 0);
    endtask

    task automatic probe(input logic [2:0] sel, input logic [31:0] w, input logic [31:0] exp,
                         input string rq, input string what);
        probe_sel   = sel;
        probe_wdata = w;
        #1;
        chk(probe_rdata == exp, rq, what, probe_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t cv;
        vec_t fv;
        logic [31:0] es;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "reset req_ready", {31'b0, req_ready}, 1);
        chk(beat_valid == 1'b0, "R1", "reset beat_valid", {31'b0, beat_valid}, 0);
        chk(done_valid == 1'b0, "R1", "reset done_valid", {31'b0, done_valid}, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i);
        end

        // Capability probes, main instance
        probe(3'd0, 32'hFFFF_FFFF, 32'h0000_0FFF, "R9", "xlen all ones");
        probe(3'd0, 32'h0000_0000, 32'h0000_0007, "R9", "xlen zero");
        probe(3'd1, 32'h0000_0001, 32'h0000_0001, "R10", "ylen one");
        probe(3'd1, 32'hFFFF_FFFF, 32'h0000_00FF, "R10", "ylen all ones");
        probe(3'd2, 32'h0000_1237, 32'h0000_1230, "R11", "src addr align");
        probe(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFF8, "R11", "dst addr align");
        probe(3'd4, 32'h0, 32'h0000_0323, "R12", "descriptor");
        probe(3'd6, 32'hFFFF_FFFF, 32'h0, "R12", "unused select");

        // Cyclic request: two rows of one beat, wraps without completion
        cv = '{32'h0000_0100, 32'h0000_0400, 32'h0000_0010, 32'h0000_0020, 12'd7, 8'd1, 5'd5, 1'b0};
        drive_req(cv, 1'b1);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        beat_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            es = 32'h100 + 32'(k % 2) * 32'h10;
            chk(beat_src_addr == es, "R8", $sformatf("cyclic beat%0d src", k), beat_src_addr, es);
            chk(beat_req_last == (k % 2 == 1), "R8", $sformatf("cyclic beat%0d req_last", k),
                {31'b0, beat_req_last}, {31'b0, k % 2 == 1});
            chk(done_valid == 1'b0, "R8", $sformatf("cyclic beat%0d no done", k), {31'b0, done_valid}, 0);
            tick();
        end
        chk(done_valid == 1'b0 && beat_valid == 1'b1, "R8", "cyclic still running",
            {30'b0, done_valid, beat_valid}, 32'h1);
        beat_ready = 1'b0;
        req_cyclic = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(req_ready == 1'b1 && beat_valid == 1'b0, "R1", "reset after cyclic",
            {30'b0, req_ready, beat_valid}, 32'h2);

        // Flat instance with streaming destination
        f_probe_sel = 3'd1;
        probe_wdata = 32'h1;
        #1;
        chk(f_probe_rdata == 32'h0, "R10", "flat ylen reads zero", f_probe_rdata, 32'h0);
        f_probe_sel = 3'd3;
        probe_wdata = 32'hFFFF_FFFF;
        #1;
        chk(f_probe_rdata == 32'h0, "R11", "stream dst addr reads zero", f_probe_rdata, 32'h0);
        f_probe_sel = 3'd4;
        #1;
        chk(f_probe_rdata == 32'h0000_0123, "R12", "flat descriptor", f_probe_rdata, 32'h123);

        fv = '{32'h0000_0040, 32'h0000_5000, 32'h0000_0100, 32'h0000_0100, 12'd15, 8'd3, 5'd12, 1'b0};
        drive_req(fv, 1'b0);
        f_req_valid = 1'b1;
        tick();
        f_req_valid = 1'b0;
        f_beat_ready = 1'b1;
        for (int b = 0; b < 2; b++) begin
            es = 32'h40 + 32'(b * 8);
            chk(f_beat_src_addr == es, "R10", $sformatf("flat beat%0d src", b), f_beat_src_addr, es);
            chk(f_beat_dst_addr == 32'h0, "R11", $sformatf("flat beat%0d dst zero", b), f_beat_dst_addr, 32'h0);
            chk(f_beat_req_last == (b == 1), "R10", $sformatf("flat beat%0d req_last", b),
                {31'b0, f_beat_req_last}, {31'b0, b == 1});
            tick();
        end
        f_beat_ready = 1'b0;
        chk(f_done_valid == 1'b1 && f_done_id == 5'd12, "R10", "flat single row done",
            {26'b0, f_done_valid, f_done_id}, {26'b0, 1'b1, 5'd12});
        chk(f_beat_valid == 1'b0, "R10", "flat no second row", {31'b0, f_beat_valid}, 0);
        tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule